// File: doc/BRIEF.md
# Parallel-Bus ADC Host Sequencer

This block is the host side of a byte-wide parallel link to a 12-bit successive-approximation converter. A client hands it one conversion request: channel number, single-ended or pseudo-differential input, unipolar or bipolar range, a two-bit power setting, and whether the sampling window is timed by the converter or by the host. The sequencer lowers chip-select, drives the control byte under a write strobe, and for host-timed sampling issues a second write after a programmable acquisition time. It then waits for the converter's active-low done line, reads the low byte and then the upper nibble by toggling the byte-select line, and presents the 12-bit word with a one-cycle valid pulse.

All bus timing is counted in system clock cycles. Strobe widths, the acquisition window, a guard time after each conversion start and a done-line timeout are run-time inputs. An abort input throws away the conversion in flight and replays the same request from its first write. The done line is brought in through a synchronizer, so its timing relative to the system clock does not matter.

Top module: `padc_host`

## Requirements
- R1: While the write strobe is low, the bus output carries the control byte with power setting in bits [7:6], the host-timed flag in bit 5, single-ended in bit 4, unipolar in bit 3 and channel in bits [2:0], and the output enable is high. The output enable is low in every other cycle.
- R2: A converter-timed request (req_ext_acq=0) produces exactly one write, with bit 5 clear, and then waits for the done line.
- R3: A host-timed request (req_ext_acq=1) produces two writes. The first has bit 5 set and the second has it clear. All other bits are identical. The write strobe stays high for exactly max(cfg_acq_len,1) cycles between them.
- R4: Every write strobe stays low for max(cfg_wr_len,1) cycles. A zero length behaves as one.
- R5: After the write that starts a conversion is released, no write strobe falls within cfg_guard cycles, and req_ready stays low until that guard has run out.
- R6: Chip-select stays low from the first write until the second read of a transaction is finished. No strobe is low while chip-select is high, and the two strobes are never low together.
- R7: Once the done line is seen low, the block reads with byte-select low and then with byte-select high. Each read strobe is low for max(cfg_rd_len,1) cycles, with one cycle high between the two reads. The block does not wait for the done line a second time. It then raises res_valid for exactly one cycle with res_data = {high read [3:0], low read [7:0]}.
- R8: If the done line is not seen low within cfg_timeout cycles of conversion start, err_timeout pulses for one cycle, chip-select returns high, and no result is given.
- R9: An abort during a busy transaction discards the pending result. Once the guard has elapsed, the block repeats the request from its first write with the same control fields. Exactly one result follows.
- R10: req_ready is high only when idle. Requests offered while busy are ignored and cause no write.
- R11: In reset and right after it, chip-select and both strobes are high, byte-select, output enable, res_valid and err_timeout are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Conversion request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_chan | input | 3 | Channel select |
| req_single | input | 1 | 1 = single-ended, 0 = pseudo-differential |
| req_unipolar | input | 1 | 1 = unipolar, 0 = bipolar |
| req_pwr | input | 2 | Power/clock setting placed in bits [7:6] |
| req_ext_acq | input | 1 | 1 = host-timed acquisition with two writes |
| cfg_wr_len | input | STRB_W | Write strobe low width in cycles |
| cfg_rd_len | input | STRB_W | Read strobe low width in cycles |
| cfg_acq_len | input | ACQ_W | Host-timed acquisition window in cycles |
| cfg_guard | input | GRD_W | Cycles after conversion start with no write allowed |
| cfg_timeout | input | TMO_W | Cycles allowed for the done line |
| abort | input | 1 | Discard the current conversion and restart it |
| adc_cs_n | output | 1 | Chip-select, active low |
| adc_wr_n | output | 1 | Write strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_hben | output | 1 | Byte-select: 0 low byte, 1 high nibble |
| adc_d_oe | output | 1 | Bus output enable |
| adc_d_out | output | 8 | Control byte driven onto the bus |
| adc_d_in | input | 8 | Data read from the bus |
| adc_int_n | input | 1 | Conversion done, active low |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 12 | Conversion result |
| err_timeout | output | 1 | One-cycle done-line timeout flag |

## Verification
The bench targets the host-timed pair of writes. A design that rewrote the channel bits, left bit 5 set on the second write, or miscounted the acquisition window would show a wrong byte or a wrong high-time gap. Abort is applied during the conversion wait while the guard is still running, and again during the acquisition window. A design that restarted at once would break the guard spacing, and one that kept the stale result would return two results. The done line is held inactive to check the exact timeout cycle and that no result appears. A zero strobe length and requests offered while busy are also checked, so a design that produced a zero-width strobe or issued an extra write would be reported.

// File: rtl/padc_pkg.sv
package padc_pkg;

  localparam int BUS_W = 8;
  localparam int RES_W = 12;
  localparam int HI_W  = RES_W - BUS_W;
  localparam int CH_W  = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WR1, ST_ACQ, ST_WR2, ST_WAIT,
    ST_RDL, ST_GAP, ST_RDH, ST_DONE, ST_REST
  } padc_state_e;

  // bit order matches the converter's control byte decode
  typedef struct packed {
    logic [1:0]      pwr;
    logic            acq;
    logic            sgl;
    logic            uni;
    logic [CH_W-1:0] ch;
  } padc_ctl_t;

endpackage

// File: rtl/padc_cnt.sv
module padc_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/padc_sync.sv
module padc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/padc_rdata.sv
module padc_rdata
  import padc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_lo,
  input  logic             cap_hi,
  input  logic [BUS_W-1:0] din,
  output logic [RES_W-1:0] result
);
  logic [BUS_W-1:0] lo_q;
  logic [HI_W-1:0]  hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_q <= '0;
    else if (cap_lo) lo_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (cap_hi) hi_q <= din[HI_W-1:0];
  end

  assign result = {hi_q, lo_q};
endmodule

// File: rtl/padc_seq.sv
module padc_seq
  import padc_pkg::*;
#(
  parameter int PH_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  padc_ctl_t        req_ctl,
  input  logic [PH_W-1:0]  wr_len,
  input  logic [PH_W-1:0]  acq_len,
  input  logic [PH_W-1:0]  rd_len,
  input  logic             abort,
  input  logic             int_low,
  input  logic             ph_done,
  input  logic             to_done,
  input  logic             grd_done,
  output logic             ph_load,
  output logic [PH_W-1:0]  ph_val,
  output logic             cv_start,
  output logic             to_dec,
  output logic             req_ready,
  output logic             cs_n,
  output logic             wr_n,
  output logic             rd_n,
  output logic             hben,
  output logic             d_oe,
  output logic [BUS_W-1:0] d_out,
  output logic             cap_lo,
  output logic             cap_hi,
  output logic             res_valid,
  output logic             err_timeout
);
  padc_state_e st_q, st_d;
  padc_ctl_t   ctl_q;
  logic        ctl_en;
  logic        pend_q, pend_d;
  logic        err_q, err_d;
  logic        abort_any;
  logic        in_wr;

  function automatic logic [PH_W-1:0] len_m1(input logic [PH_W-1:0] v);
    return (v == '0) ? '0 : v - PH_W'(1);
  endfunction

  assign abort_any = abort | pend_q;

  always_comb begin
    st_d     = st_q;
    ctl_en   = 1'b0;
    ph_load  = 1'b0;
    ph_val   = '0;
    cv_start = 1'b0;
    err_d    = 1'b0;
    cap_lo   = 1'b0;
    cap_hi   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid && grd_done) begin
        ctl_en  = 1'b1;
        st_d    = ST_WR1;
        ph_load = 1'b1;
        ph_val  = len_m1(wr_len);
      end
      ST_WR1: if (ph_done) begin
        if (!ctl_q.acq) begin
          st_d     = ST_WAIT;
          cv_start = 1'b1;
        end else if (abort_any) begin
          st_d = ST_REST;
        end else begin
          st_d    = ST_ACQ;
          ph_load = 1'b1;
          ph_val  = len_m1(acq_len);
        end
      end
      ST_ACQ: begin
        if (abort_any) st_d = ST_REST;
        else if (ph_done) begin
          st_d    = ST_WR2;
          ph_load = 1'b1;
          ph_val  = len_m1(wr_len);
        end
      end
      ST_WR2: if (ph_done) begin
        st_d     = ST_WAIT;
        cv_start = 1'b1;
      end
      ST_WAIT: begin
        if (abort_any) st_d = ST_REST;
        else if (int_low) begin
          st_d    = ST_RDL;
          ph_load = 1'b1;
          ph_val  = len_m1(rd_len);
        end else if (to_done) begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end
      end
      ST_RDL: if (ph_done) begin
        cap_lo = 1'b1;
        st_d   = abort_any ? ST_REST : ST_GAP;
      end
      ST_GAP: begin
        if (abort_any) st_d = ST_REST;
        else begin
          st_d    = ST_RDH;
          ph_load = 1'b1;
          ph_val  = len_m1(rd_len);
        end
      end
      ST_RDH: if (ph_done) begin
        if (abort_any) st_d = ST_REST;
        else begin
          cap_hi = 1'b1;
          st_d   = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      ST_REST: if (grd_done) begin
        st_d    = ST_WR1;
        ph_load = 1'b1;
        ph_val  = len_m1(wr_len);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (st_q == ST_IDLE || st_q == ST_DONE || st_q == ST_REST || st_d == ST_REST)
      pend_d = 1'b0;
    else
      pend_d = pend_q | abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= req_ctl;
  end

  assign in_wr       = (st_q == ST_WR1) || (st_q == ST_WR2);
  assign wr_n        = ~in_wr;
  assign d_oe        = in_wr;
  assign d_out       = in_wr ? {ctl_q.pwr, (st_q == ST_WR1) & ctl_q.acq,
                                ctl_q.sgl, ctl_q.uni, ctl_q.ch} : '0;
  assign rd_n        = ~((st_q == ST_RDL) || (st_q == ST_RDH));
  assign hben        = (st_q == ST_GAP) || (st_q == ST_RDH);
  assign cs_n        = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign req_ready   = (st_q == ST_IDLE) && grd_done;
  assign res_valid   = (st_q == ST_DONE);
  assign err_timeout = err_q;
  assign to_dec      = (st_q == ST_WAIT);

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));
  a_r6_strobe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |-> !cs_n);
  a_r5_guard_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> grd_done);
  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r7_hben_steady_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |-> $stable(hben));
  a_r8_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> !err_timeout);
  a_r8_err_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (cs_n && !res_valid));
  a_r10_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);
  a_r1_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> !cs_n);
endmodule

// File: rtl/padc_host.sv
module padc_host
  import padc_pkg::*;
#(
  parameter int STRB_W = 8,
  parameter int ACQ_W  = 16,
  parameter int GRD_W  = 8,
  parameter int TMO_W  = 20,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_chan,
  input  logic              req_single,
  input  logic              req_unipolar,
  input  logic [1:0]        req_pwr,
  input  logic              req_ext_acq,
  input  logic [STRB_W-1:0] cfg_wr_len,
  input  logic [STRB_W-1:0] cfg_rd_len,
  input  logic [ACQ_W-1:0]  cfg_acq_len,
  input  logic [GRD_W-1:0]  cfg_guard,
  input  logic [TMO_W-1:0]  cfg_timeout,
  input  logic              abort,
  output logic              adc_cs_n,
  output logic              adc_wr_n,
  output logic              adc_rd_n,
  output logic              adc_hben,
  output logic              adc_d_oe,
  output logic [BUS_W-1:0]  adc_d_out,
  input  logic [BUS_W-1:0]  adc_d_in,
  input  logic              adc_int_n,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic              err_timeout
);
  localparam int PH_W = (ACQ_W > STRB_W) ? ACQ_W : STRB_W;

  padc_ctl_t       req_ctl;
  logic            int_s;
  logic            ph_load, ph_done;
  logic [PH_W-1:0] ph_val;
  logic            cv_start, to_dec, to_done, grd_done;
  logic            cap_lo, cap_hi;
  logic [TMO_W-1:0] tmo_m1;

  assign req_ctl = '{pwr: req_pwr, acq: req_ext_acq, sgl: req_single,
                     uni: req_unipolar, ch: req_chan};
  assign tmo_m1  = (cfg_timeout == '0) ? '0 : cfg_timeout - TMO_W'(1);

  padc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_int_sync (
    .clk(clk), .rst_n(rst_n), .d(adc_int_n), .q(int_s));

  padc_cnt #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val),
    .dec(1'b1), .zero(ph_done));

  padc_cnt #(.W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .load(cv_start), .load_val(tmo_m1),
    .dec(to_dec), .zero(to_done));

  padc_cnt #(.W(GRD_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .load(cv_start), .load_val(cfg_guard),
    .dec(1'b1), .zero(grd_done));

  padc_seq #(.PH_W(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ctl(req_ctl),
    .wr_len(PH_W'(cfg_wr_len)), .acq_len(PH_W'(cfg_acq_len)),
    .rd_len(PH_W'(cfg_rd_len)),
    .abort(abort), .int_low(~int_s),
    .ph_done(ph_done), .to_done(to_done), .grd_done(grd_done),
    .ph_load(ph_load), .ph_val(ph_val), .cv_start(cv_start), .to_dec(to_dec),
    .req_ready(req_ready), .cs_n(adc_cs_n), .wr_n(adc_wr_n), .rd_n(adc_rd_n),
    .hben(adc_hben), .d_oe(adc_d_oe), .d_out(adc_d_out),
    .cap_lo(cap_lo), .cap_hi(cap_hi), .res_valid(res_valid),
    .err_timeout(err_timeout));

  padc_rdata u_rdata (
    .clk(clk), .rst_n(rst_n), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .din(adc_d_in), .result(res_data));

  a_r1_oe_matches_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    adc_d_oe == !adc_wr_n);
endmodule

// File: tb/tb_padc_host.sv
module tb_padc_host;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_single = 0, req_unipolar = 0, req_ext_acq = 0;
  logic [2:0]  req_chan = 0;
  logic [1:0]  req_pwr = 0;
  logic [7:0]  cfg_wr_len = 2, cfg_rd_len = 3, cfg_guard = 4;
  logic [15:0] cfg_acq_len = 5;
  logic [19:0] cfg_timeout = 200;
  logic        abort = 0;
  wire         req_ready, adc_cs_n, adc_wr_n, adc_rd_n, adc_hben, adc_d_oe;
  wire  [7:0]  adc_d_out, adc_d_in;
  wire         res_valid, err_timeout;
  wire  [11:0] res_data;
  logic        int_r = 1'b1;
  logic [11:0] val_r = 12'h000;

  assign adc_d_in = !adc_rd_n ? (adc_hben ? {4'h0, val_r[11:8]} : val_r[7:0]) : 8'h5A;

  padc_host dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_single(req_single), .req_unipolar(req_unipolar),
    .req_pwr(req_pwr), .req_ext_acq(req_ext_acq), .cfg_wr_len(cfg_wr_len),
    .cfg_rd_len(cfg_rd_len), .cfg_acq_len(cfg_acq_len), .cfg_guard(cfg_guard),
    .cfg_timeout(cfg_timeout), .abort(abort), .adc_cs_n(adc_cs_n),
    .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n), .adc_hben(adc_hben),
    .adc_d_oe(adc_d_oe), .adc_d_out(adc_d_out), .adc_d_in(adc_d_in),
    .adc_int_n(int_r), .res_valid(res_valid), .res_data(res_data),
    .err_timeout(err_timeout));

  int nchk = 0, nerr = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural converter model and bus monitor
  int wlen_q[$], wbyte_q[$], gap_q[$], rlen_q[$], rhb_q[$], res_q[$];
  int cyc = 0, conv_cyc = 0, err_cyc = 0, err_cnt = 0, cs_rises = 0, busy_oe_bad = 0;
  int lat = 6, conv_cnt = -1, wl = 0, rl = 0, hi_run = 0, wb = 0;
  bit suppress = 0, prev_wr = 1, prev_rd = 1, prev_cs = 1;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (conv_cnt > 0) conv_cnt--;
      else if (conv_cnt == 0) begin
        if (!suppress) int_r = 1'b0;
        conv_cnt = -1;
      end
      // R6 and R1: per-cycle bus rules
      check(!((!adc_wr_n || !adc_rd_n) && adc_cs_n), "R6 strobe with cs high", adc_cs_n, 0);
      check(!(!adc_wr_n && !adc_rd_n), "R6 strobes overlap", 1, 0);
      check(adc_d_oe == !adc_wr_n, "R1 output enable", adc_d_oe, !adc_wr_n);
      if (!adc_wr_n) begin
        if (prev_wr) begin gap_q.push_back(hi_run); wl = 0; end
        wl++; wb = adc_d_out; hi_run = 0;
      end else begin
        if (!prev_wr) begin
          wlen_q.push_back(wl); wbyte_q.push_back(wb); int_r = 1'b1;
          if (wb[5] == 1'b0) begin conv_cnt = lat; conv_cyc = cyc; end
          else conv_cnt = -1;
        end
        hi_run++;
      end
      if (!adc_rd_n) begin
        if (prev_rd) begin rhb_q.push_back(adc_hben); rl = 0; int_r = 1'b1; end
        rl++;
      end else if (!prev_rd) rlen_q.push_back(rl);
      if (adc_cs_n && !prev_cs) cs_rises++;
      if (res_valid) res_q.push_back(res_data);
      if (err_timeout) begin err_cnt++; err_cyc = cyc; end
      prev_wr = adc_wr_n; prev_rd = adc_rd_n; prev_cs = adc_cs_n;
    end
  end

  task automatic clear_logs();
    wlen_q.delete(); wbyte_q.delete(); gap_q.delete();
    rlen_q.delete(); rhb_q.delete(); res_q.delete(); cs_rises = 0;
  endtask

  task automatic send(input bit ext, input bit [1:0] pwr, input bit sgl,
                      input bit uni, input bit [2:0] ch);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_ext_acq = ext; req_pwr = pwr;
    req_single = sgl; req_unipolar = uni; req_chan = ch;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_end(input int e0);
    int n = 0;
    while (res_q.size() == 0 && err_cnt == e0 && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  function automatic int ctl_byte(bit [1:0] pwr, bit acq, bit sgl, bit uni, bit [2:0] ch);
    return {pwr, acq, sgl, uni, ch};
  endfunction

  task automatic run_plain(input bit ext, input bit [1:0] pwr, input bit sgl,
                           input bit uni, input bit [2:0] ch, input bit [11:0] v);
    int e0 = err_cnt;
    int wexp = (cfg_wr_len == 0) ? 1 : cfg_wr_len;
    int rexp = (cfg_rd_len == 0) ? 1 : cfg_rd_len;
    int aexp = (cfg_acq_len == 0) ? 1 : cfg_acq_len;
    clear_logs(); val_r = v;
    send(ext, pwr, sgl, uni, ch);
    wait_end(e0);
    if (ext) begin
      check(wbyte_q.size() == 2, "R3 write count", wbyte_q.size(), 2);
      if (wbyte_q.size() == 2) begin
        check(wbyte_q[0] == ctl_byte(pwr, 1, sgl, uni, ch), "R3 first byte", wbyte_q[0], ctl_byte(pwr, 1, sgl, uni, ch));
        check(wbyte_q[1] == ctl_byte(pwr, 0, sgl, uni, ch), "R3 second byte", wbyte_q[1], ctl_byte(pwr, 0, sgl, uni, ch));
        check(gap_q[1] == aexp, "R3 acquisition gap", gap_q[1], aexp);
      end
    end else begin
      check(wbyte_q.size() == 1, "R2 write count", wbyte_q.size(), 1);
      if (wbyte_q.size() >= 1)
        check(wbyte_q[0] == ctl_byte(pwr, 0, sgl, uni, ch), "R1 R2 control byte", wbyte_q[0], ctl_byte(pwr, 0, sgl, uni, ch));
    end
    foreach (wlen_q[i]) check(wlen_q[i] == wexp, "R4 write width", wlen_q[i], wexp);
    check(rlen_q.size() == 2, "R7 read count", rlen_q.size(), 2);
    if (rlen_q.size() == 2) begin
      check(rlen_q[0] == rexp && rlen_q[1] == rexp, "R7 read width", rlen_q[0], rexp);
      check(rhb_q[0] == 0 && rhb_q[1] == 1, "R7 byte-select order", rhb_q[0] * 2 + rhb_q[1], 1);
    end
    check(res_q.size() == 1, "R7 result count", res_q.size(), 1);
    if (res_q.size() == 1) check(res_q[0] == v, "R7 result value", res_q[0], v);
    check(cs_rises == 1, "R6 chip-select held", cs_rises, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    int e0, g0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(adc_cs_n && adc_wr_n && adc_rd_n, "R11 strobes idle", {adc_cs_n, adc_wr_n, adc_rd_n}, 7);
    check(!adc_hben && !adc_d_oe && !res_valid && !err_timeout, "R11 outputs low",
          {adc_hben, adc_d_oe, res_valid, err_timeout}, 0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R11 ready after reset", req_ready, 1);

    run_plain(0, 2'b10, 1, 1, 3'd5, 12'hABC);
    run_plain(1, 2'b11, 0, 1, 3'd2, 12'h3C7);
    run_plain(1, 2'b01, 1, 0, 3'd7, 12'hF01);
    cfg_wr_len = 0; cfg_rd_len = 1; cfg_acq_len = 0;
    run_plain(1, 2'b00, 1, 1, 3'd0, 12'h800);
    run_plain(0, 2'b11, 0, 0, 3'd6, 12'h7FF);
    cfg_wr_len = 3; cfg_rd_len = 2; cfg_acq_len = 9;

    // R10: requests while busy are ignored
    clear_logs(); lat = 40; val_r = 12'h456; e0 = err_cnt;
    send(0, 2'b10, 1, 1, 3'd1);
    repeat (5) @(negedge clk);
    check(req_ready == 0, "R10 ready low while busy", req_ready, 0);
    req_valid = 1; req_chan = 3'd6;
    repeat (8) @(negedge clk);
    req_valid = 0;
    wait_end(e0);
    check(wbyte_q.size() == 1, "R10 no extra write", wbyte_q.size(), 1);
    check(res_q.size() == 1 && res_q[0] == 12'h456, "R10 result intact", res_q.size(), 1);

    // R9 + R5: abort during the wait while the guard is running
    clear_logs(); cfg_guard = 12; val_r = 12'h9A5; e0 = err_cnt;
    send(0, 2'b10, 0, 1, 3'd3);
    while (wlen_q.size() < 1) @(negedge clk);
    repeat (2) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    wait_end(e0);
    check(wbyte_q.size() == 2, "R9 fresh write count", wbyte_q.size(), 2);
    if (wbyte_q.size() == 2) begin
      check(wbyte_q[1] == wbyte_q[0], "R9 same control byte", wbyte_q[1], wbyte_q[0]);
      check(gap_q[1] >= 12, "R5 guard before rewrite", gap_q[1], 12);
    end
    repeat (20) @(negedge clk);
    check(res_q.size() == 1 && res_q[0] == 12'h9A5, "R9 single result", res_q.size(), 1);

    // R9: abort inside the acquisition window
    clear_logs(); cfg_acq_len = 30; lat = 6; val_r = 12'h0E3; e0 = err_cnt;
    send(1, 2'b11, 1, 0, 3'd4);
    while (wlen_q.size() < 1) @(negedge clk);
    repeat (3) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    wait_end(e0);
    check(wbyte_q.size() == 3, "R9 writes after acq abort", wbyte_q.size(), 3);
    if (wbyte_q.size() == 3)
      check(wbyte_q[1] == ctl_byte(2'b11, 1, 1, 0, 3'd4), "R9 restart first byte", wbyte_q[1], ctl_byte(2'b11, 1, 1, 0, 3'd4));
    check(res_q.size() == 1 && res_q[0] == 12'h0E3, "R9 result after acq abort", res_q.size(), 1);

    // R8: done line never arrives
    clear_logs(); cfg_timeout = 30; cfg_guard = 4; suppress = 1; e0 = err_cnt;
    send(0, 2'b10, 1, 1, 3'd2);
    wait_end(e0);
    g0 = err_cyc - conv_cyc;
    check(err_cnt == e0 + 1, "R8 timeout flagged once", err_cnt - e0, 1);
    check(g0 == 30, "R8 timeout cycle", g0, 30);
    check(res_q.size() == 0, "R8 no result", res_q.size(), 0);
    check(adc_cs_n == 1, "R8 chip-select released", adc_cs_n, 1);
    suppress = 0; cfg_timeout = 200;

    run_plain(0, 2'b10, 1, 1, 3'd7, 12'h5A5);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule